// File: doc/BRIEF.md
# Nested Exception Entry Sequencer

This block decides when a processor leaves its current context for an exception handler and how it comes back. It keeps its own pending register. Pulses on `req_set` set its bits, and each exception number has a fixed priority in `exc_prio`. It also keeps a record of the handlers that are nested at the moment. When it accepts an exception it issues a one-cycle vector-fetch request. On a normal entry it pushes an eight-word context frame through a word-at-a-time stack port. When a handler ends it either chains straight into the next eligible handler or pops the frame back.

Two fast paths shape the design. In the first, a higher-priority request that arrives while a frame is being saved, or before the new handler's first instruction executes, only retargets the vector fetch. The save keeps running, because the frame is identical for both exceptions. In the second, a handler that completes while an eligible request is waiting hands over to that request without any pop or push.

The controller is a four-state machine:
- RUN: executing thread code or a handler.
- STACK: pushing a frame.
- WAIT_EXEC: the frame is saved and the first handler instruction has not yet executed.
- POP: restoring a frame.

The transitions are:
- preempt: RUN to STACK.
- stack_done: STACK to WAIT_EXEC.
- first_exec: WAIT_EXEC to RUN.
- unwind: RUN to POP.
- pop_done: POP to RUN.
- late_switch: STACK or WAIT_EXEC to itself.
- tail_chain: RUN to RUN.

Top module: `nest_exc_sequencer`

## Requirements
- R1: A pending exception is eligible only when its priority value is numerically below `mask_lim`; `mask_lim` = 8 masks nothing. A masked request stays pending and is served once the limit rises above its priority.
- R2: In thread mode (`act_depth` = 0) any eligible request is taken. Inside a handler, a request is taken only if its priority value is strictly below `act_prio`. A request that does not qualify causes no fetch.
- R3: Among eligible requests the lowest priority value wins. On equal priority the lowest exception number wins.
- R4: On a normal entry, `vec_req` is high for one cycle with `vec_num` set to the winner. Then eight push beats (`stk_push` = 1) follow at addresses SP-4, SP-8, … SP-32, with `stk_idx` running 0 to 7. SP starts at 0x2000_8000 and drops by 32 per frame.
- R5: `stk_valid` stays high, with `stk_addr` and `stk_idx` unchanged, until a cycle with `stk_ready` high. Exactly one beat moves in each such cycle.
- R6: During STACK or WAIT_EXEC, an eligible request with a priority value below `act_prio` raises another `vec_req` with the new number. This causes no extra push beats and leaves `act_depth` unchanged. The displaced exception becomes pending again.
- R7: Once `first_exec` has been seen, a higher-priority request preempts normally with its own eight-beat frame, and `act_depth` increases by one.
- R8: When `hdl_done` arrives and an eligible request beats the context below the current handler, a `vec_req` is issued in that same cycle and no pop or push beats occur.
- R9: When `hdl_done` arrives and nothing qualifies, eight pop beats (`stk_push` = 0) follow at addresses SP, SP+4, … SP+28, with `stk_idx` running 7 down to 0. After that `act_depth` drops by one, and `thread_mode` rises when it reaches 0.
- R10: `act_depth` counts nested handlers, up to 8 levels. `act_prio` gives the priority of the innermost handler, and reads 0 in thread mode.
- R11: After reset: `thread_mode` = 1, `act_depth` = 0, `stk_valid` = 0, `vec_req` = 0, and nothing is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_set | input | 8 | One-cycle pulses that set pending bits |
| exc_prio | input | 24 | 3-bit priority per exception; exception i at bits [3i+2:3i] |
| mask_lim | input | 4 | Priority limit; a value must be below it to be eligible |
| first_exec | input | 1 | First handler instruction reached execute |
| hdl_done | input | 1 | Current handler completed |
| stk_ready | input | 1 | Stack port accepts the current beat |
| stk_valid | output | 1 | Stack beat offered |
| stk_push | output | 1 | 1 = write (push), 0 = read (pop) |
| stk_addr | output | 32 | Byte address of the beat |
| stk_idx | output | 3 | Frame word index of the beat |
| vec_req | output | 1 | Vector fetch request, one cycle |
| vec_num | output | 3 | Exception number to fetch |
| thread_mode | output | 1 | No handler active |
| act_depth | output | 4 | Number of nested handlers |
| act_prio | output | 3 | Priority of the innermost handler |

## Verification
The hard overlaps are a late-arriving request landing while the frame save is running, and a handler completion landing while a request is already pending. The late case is provoked in two places. In one, the second request is raised in the cycle the first fetch goes out, so the retarget falls on the first push beat. In the other, the second request is raised after the last beat but before `first_exec`. The late case is judged by a second fetch with exactly eight push beats, followed by a tail-chain back to the displaced exception. Completion with a pending request is swept over every pair of priorities, and the bench predicts either a preempt or a zero-beat tail-chain.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;
    typedef enum logic [1:0] {
        S_RUN,
        S_STACK,
        S_WAIT_EXEC,
        S_POP
    } seq_state_t;

    typedef enum logic [1:0] {
        ACT_NONE,
        ACT_PUSH,
        ACT_REPL,
        ACT_POP
    } act_op_t;
endpackage

// File: rtl/exc_pick.sv
module exc_pick #(
    parameter int N  = 8,
    parameter int PW = 3,
    parameter int IW = 3
) (
    input  logic [N-1:0]    pend,
    input  logic [N*PW-1:0] prio_flat,
    input  logic [PW:0]     mask_lim,
    output logic            win_valid,
    output logic [IW-1:0]   win_num,
    output logic [PW-1:0]   win_prio
);
    logic [N:0]    v_ch;
    logic [PW-1:0] p_ch [N+1];
    logic [IW-1:0] n_ch [N+1];

    assign v_ch[0] = 1'b0;
    assign p_ch[0] = '0;
    assign n_ch[0] = '0;

    // ascending scan with strict compare keeps the lowest number on ties
    for (genvar i = 0; i < N; i++) begin : g_scan
        logic [PW-1:0] pi;
        logic          cand;
        logic          take;
        assign pi   = prio_flat[i*PW +: PW];
        assign cand = pend[i] && ({1'b0, pi} < mask_lim);
        assign take = cand && (!v_ch[i] || (pi < p_ch[i]));
        assign v_ch[i+1] = v_ch[i] | cand;
        assign p_ch[i+1] = take ? pi : p_ch[i];
        assign n_ch[i+1] = take ? IW'(i) : n_ch[i];
    end

    assign win_valid = v_ch[N];
    assign win_num   = n_ch[N];
    assign win_prio  = p_ch[N];
endmodule

// File: rtl/act_stack.sv
module act_stack
    import exc_seq_pkg::*;
#(
    parameter int PW    = 3,
    parameter int IW    = 3,
    parameter int DEPTH = 8,
    parameter int CW    = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  act_op_t       op,
    input  logic [PW-1:0] in_prio,
    input  logic [IW-1:0] in_num,
    output logic [CW-1:0] depth,
    output logic [PW-1:0] top_prio,
    output logic [IW-1:0] top_num,
    output logic [PW-1:0] below_prio
);
    localparam int IXW = $clog2(DEPTH);

    logic [PW-1:0] prio_q [DEPTH];
    logic [IW-1:0] num_q  [DEPTH];
    logic [CW-1:0] cnt;
    logic [IXW-1:0] top_ix;
    logic [IXW-1:0] below_ix;

    assign top_ix   = IXW'(cnt - CW'(1));
    assign below_ix = IXW'(cnt - CW'(2));
    assign depth      = cnt;
    assign top_prio   = (cnt != '0) ? prio_q[top_ix] : '0;
    assign top_num    = (cnt != '0) ? num_q[top_ix] : '0;
    assign below_prio = (cnt > CW'(1)) ? prio_q[below_ix] : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            for (int k = 0; k < DEPTH; k++) begin
                prio_q[k] <= '0;
                num_q[k]  <= '0;
            end
        end else begin
            unique case (op)
                ACT_PUSH: begin
                    prio_q[cnt[IXW-1:0]] <= in_prio;
                    num_q[cnt[IXW-1:0]]  <= in_num;
                    cnt <= cnt + CW'(1);
                end
                ACT_REPL: begin
                    prio_q[top_ix] <= in_prio;
                    num_q[top_ix]  <= in_num;
                end
                ACT_POP:  cnt <= cnt - CW'(1);
                ACT_NONE: ;
            endcase
        end
    end

    // R10
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == ACT_PUSH) |-> (cnt < CW'(DEPTH)));
    // R9
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((op == ACT_POP) || (op == ACT_REPL)) |-> (cnt != '0));
endmodule

// File: rtl/frame_mover.sv
module frame_mover #(
    parameter int          AW        = 32,
    parameter int          FW        = 8,
    parameter int          BW        = 3,
    parameter logic [31:0] STACK_TOP = 32'h2000_8000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          start_push,
    input  logic          stk_ready,
    output logic          stk_valid,
    output logic          stk_push,
    output logic [AW-1:0] stk_addr,
    output logic [BW-1:0] stk_idx,
    output logic          fin
);
    localparam int FRAME_BYTES = FW * 4;

    logic          active;
    logic          dir;
    logic [BW-1:0] beat;
    logic [AW-1:0] sp;
    logic [AW-1:0] offs;
    logic          last;

    assign offs      = AW'({beat, 2'b00});
    assign last      = (beat == BW'(FW - 1));
    assign fin       = active && stk_ready && last;
    assign stk_valid = active;
    assign stk_push  = dir;
    assign stk_idx   = dir ? beat : (BW'(FW - 1) - beat);
    assign stk_addr  = dir ? (sp - offs - AW'(4)) : (sp + offs);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            dir    <= 1'b0;
            beat   <= '0;
            sp     <= AW'(STACK_TOP);
        end else if (start) begin
            active <= 1'b1;
            dir    <= start_push;
            beat   <= '0;
        end else if (active && stk_ready) begin
            if (last) begin
                active <= 1'b0;
                beat   <= '0;
                sp     <= dir ? (sp - AW'(FRAME_BYTES)) : (sp + AW'(FRAME_BYTES));
            end else begin
                beat <= beat + BW'(1);
            end
        end
    end

    // R5
    beat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stk_valid && !stk_ready) |=> (stk_valid && $stable(stk_addr) && $stable(stk_idx)));
    // R4
    no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !active);
endmodule

// File: rtl/nest_exc_sequencer.sv
module nest_exc_sequencer
    import exc_seq_pkg::*;
#(
    parameter int          N_EXC       = 8,
    parameter int          PRIO_W      = 3,
    parameter int          FRAME_WORDS = 8,
    parameter int          ADDR_W      = 32,
    parameter logic [31:0] STACK_TOP   = 32'h2000_8000,
    localparam int IW    = $clog2(N_EXC),
    localparam int DEPTH = 1 << PRIO_W,
    localparam int CW    = $clog2(DEPTH + 1),
    localparam int BW    = $clog2(FRAME_WORDS)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [N_EXC-1:0]        req_set,
    input  logic [N_EXC*PRIO_W-1:0] exc_prio,
    input  logic [PRIO_W:0]         mask_lim,
    input  logic                    first_exec,
    input  logic                    hdl_done,
    input  logic                    stk_ready,
    output logic                    stk_valid,
    output logic                    stk_push,
    output logic [ADDR_W-1:0]       stk_addr,
    output logic [BW-1:0]           stk_idx,
    output logic                    vec_req,
    output logic [IW-1:0]           vec_num,
    output logic                    thread_mode,
    output logic [CW-1:0]           act_depth,
    output logic [PRIO_W-1:0]       act_prio
);
    seq_state_t state_q, state_d;

    logic [N_EXC-1:0]  pend_q;
    logic [N_EXC-1:0]  clr_vec, rest_vec;
    logic              win_valid;
    logic [IW-1:0]     win_num;
    logic [PRIO_W-1:0] win_prio;
    logic [IW-1:0]     top_num;
    logic [PRIO_W-1:0] below_prio;
    act_op_t           aop;
    logic              mv_start, mv_push, mv_fin;
    logic              preempt_ok, tail_ok, late_ok;

    exc_pick #(.N(N_EXC), .PW(PRIO_W), .IW(IW)) u_pick (
        .pend      (pend_q),
        .prio_flat (exc_prio),
        .mask_lim  (mask_lim),
        .win_valid (win_valid),
        .win_num   (win_num),
        .win_prio  (win_prio)
    );

    act_stack #(.PW(PRIO_W), .IW(IW), .DEPTH(DEPTH), .CW(CW)) u_act (
        .clk        (clk),
        .rst_n      (rst_n),
        .op         (aop),
        .in_prio    (win_prio),
        .in_num     (win_num),
        .depth      (act_depth),
        .top_prio   (act_prio),
        .top_num    (top_num),
        .below_prio (below_prio)
    );

    frame_mover #(.AW(ADDR_W), .FW(FRAME_WORDS), .BW(BW), .STACK_TOP(STACK_TOP)) u_mov (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (mv_start),
        .start_push (mv_push),
        .stk_ready  (stk_ready),
        .stk_valid  (stk_valid),
        .stk_push   (stk_push),
        .stk_addr   (stk_addr),
        .stk_idx    (stk_idx),
        .fin        (mv_fin)
    );

    assign thread_mode = (act_depth == '0);
    assign preempt_ok  = win_valid && (thread_mode || (win_prio < act_prio));
    assign tail_ok     = win_valid && ((act_depth == CW'(1)) || (win_prio < below_prio));
    assign late_ok     = win_valid && (win_prio < act_prio);
    assign vec_num     = win_num;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_RUN;
        else        state_q <= state_d;
    end

    // pending register: set by requests, cleared on fetch, restored when displaced
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= ((pend_q | req_set) & ~clr_vec) | rest_vec;
    end

    // next state and outputs
    always_comb begin
        state_d  = state_q;
        vec_req  = 1'b0;
        clr_vec  = '0;
        rest_vec = '0;
        aop      = ACT_NONE;
        mv_start = 1'b0;
        mv_push  = 1'b0;
        unique case (state_q)
            S_RUN: begin
                if (hdl_done && !thread_mode) begin
                    if (tail_ok) begin
                        vec_req = 1'b1;
                        clr_vec = N_EXC'(1) << win_num;
                        aop     = ACT_REPL;
                    end else begin
                        mv_start = 1'b1;
                        state_d  = S_POP;
                    end
                end else if (preempt_ok) begin
                    vec_req  = 1'b1;
                    clr_vec  = N_EXC'(1) << win_num;
                    aop      = ACT_PUSH;
                    mv_start = 1'b1;
                    mv_push  = 1'b1;
                    state_d  = S_STACK;
                end
            end
            S_STACK: begin
                if (late_ok) begin
                    vec_req  = 1'b1;
                    clr_vec  = N_EXC'(1) << win_num;
                    rest_vec = N_EXC'(1) << top_num;
                    aop      = ACT_REPL;
                end
                if (mv_fin) state_d = S_WAIT_EXEC;
            end
            S_WAIT_EXEC: begin
                if (first_exec) begin
                    state_d = S_RUN;
                end else if (late_ok) begin
                    vec_req  = 1'b1;
                    clr_vec  = N_EXC'(1) << win_num;
                    rest_vec = N_EXC'(1) << top_num;
                    aop      = ACT_REPL;
                end
            end
            S_POP: begin
                if (mv_fin) begin
                    aop     = ACT_POP;
                    state_d = S_RUN;
                end
            end
        endcase
    end

    // R9
    pop_no_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_POP) |-> !vec_req);
    // R9
    pop_not_thread_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stk_valid && !stk_push) |-> !thread_mode);
    // R6
    late_keeps_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (((state_q == S_STACK) || (state_q == S_WAIT_EXEC)) && vec_req) |=> $stable(act_depth));
    // R2
    preempt_higher_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == S_RUN) && vec_req && !hdl_done)
        |=> ((act_prio < $past(act_prio)) || $past(thread_mode)));
    // R1
    fetch_unmasked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vec_req |-> ({1'b0, exc_prio[vec_num*PRIO_W +: PRIO_W]} < mask_lim));
endmodule

// File: tb/sim_nest_exc_sequencer.sv
`timescale 1ns/1ps
module sim_nest_exc_sequencer;
    localparam logic [31:0] TOP = 32'h2000_8000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  req_set = '0;
    logic [23:0] exc_prio = '1;
    logic [3:0]  mask_lim = 4'd8;
    logic        first_exec = 1'b0;
    logic        hdl_done = 1'b0;
    logic        stk_ready = 1'b1;
    logic        stk_valid, stk_push, vec_req, thread_mode;
    logic [31:0] stk_addr;
    logic [2:0]  stk_idx, vec_num, act_prio;
    logic [3:0]  act_depth;

    int checks = 0;
    int errors = 0;
    bit stall = 0;
    bit done_rep = 0;
    logic [31:0] sp_m = TOP;
    int push_k = 0, pop_k = 0, pushes = 0, pops = 0;
    bit hold_pend = 0;
    logic [31:0] hold_addr;
    bit tc_seen;
    int tc_num;

    nest_exc_sequencer u0 (
        .clk(clk), .rst_n(rst_n), .req_set(req_set), .exc_prio(exc_prio),
        .mask_lim(mask_lim), .first_exec(first_exec), .hdl_done(hdl_done),
        .stk_ready(stk_ready), .stk_valid(stk_valid), .stk_push(stk_push),
        .stk_addr(stk_addr), .stk_idx(stk_idx), .vec_req(vec_req),
        .vec_num(vec_num), .thread_mode(thread_mode), .act_depth(act_depth),
        .act_prio(act_prio)
    );

    always #2 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic report;
        if (!done_rep) begin
            done_rep = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        end
        $finish;
    endtask

    always @(posedge clk) stk_ready <= stall ? ~stk_ready : 1'b1;

    // beat monitor: R4 push addresses, R9 pop addresses, R5 hold
    always @(negedge clk) begin
        if (rst_n) begin
            if (hold_pend) begin
                chk(stk_valid && stk_addr == hold_addr, "R5 hold", stk_addr, hold_addr);
                hold_pend = 0;
            end
            if (stk_valid && stk_ready) begin
                if (stk_push) begin
                    chk(stk_addr == sp_m - 4, "R4 push addr", stk_addr, sp_m - 4);
                    chk(stk_idx == push_k, "R4 push idx", stk_idx, push_k);
                    sp_m = sp_m - 4; push_k = (push_k + 1) % 8; pushes++;
                end else begin
                    chk(stk_addr == sp_m, "R9 pop addr", stk_addr, sp_m);
                    chk(stk_idx == 7 - pop_k, "R9 pop idx", stk_idx, 7 - pop_k);
                    sp_m = sp_m + 4; pop_k = (pop_k + 1) % 8; pops++;
                end
            end else if (stk_valid) begin
                hold_pend = 1; hold_addr = stk_addr;
            end
        end
    end

    task automatic do_reset;
        rst_n = 0; req_set = '0; hdl_done = 0; first_exec = 0; mask_lim = 4'd8;
        exc_prio = '1;
        repeat (3) @(negedge clk);
        sp_m = TOP; push_k = 0; pop_k = 0; pushes = 0; pops = 0; hold_pend = 0;
        rst_n = 1;
        @(negedge clk);
    endtask

    task automatic set_prio(input int n, input int p);
        exc_prio[n*3 +: 3] = 3'(p);
    endtask

    task automatic raise(input int n);
        req_set[n] = 1'b1;
        @(negedge clk);
        req_set = '0;
    endtask

    task automatic wait_fetch(input int exp, input string tag);
        bit found = 0;
        for (int k = 0; k < 60; k++) begin
            if (vec_req) begin found = 1; break; end
            @(negedge clk);
        end
        chk(found, tag, found, 1);
        if (found) chk(vec_num == exp, tag, vec_num, exp);
        @(negedge clk);
    endtask

    task automatic no_fetch(input int n, input string tag);
        bit seen = 0;
        for (int k = 0; k < n; k++) begin
            seen |= vec_req;
            @(negedge clk);
        end
        chk(!seen, tag, seen, 0);
    endtask

    task automatic pulse_first;
        while (stk_valid) @(negedge clk);
        first_exec = 1'b1;
        @(negedge clk);
        first_exec = 1'b0;
    endtask

    task automatic do_done;
        hdl_done = 1'b1;
        #1;
        tc_seen = vec_req;
        tc_num  = vec_num;
        @(negedge clk);
        hdl_done = 1'b0;
        while (stk_valid) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        report();
    end

    initial begin
        do_reset();
        // R11 reset state
        chk(thread_mode == 1, "R11 thread", thread_mode, 1);
        chk(act_depth == 0, "R11 depth", act_depth, 0);
        chk(stk_valid == 0, "R11 valid", stk_valid, 0);
        chk(vec_req == 0, "R11 vec_req", vec_req, 0);
        no_fetch(5, "R11 nothing pending");

        // R1 mask sweep
        for (int p = 0; p < 8; p++) begin
            for (int m = 0; m <= 8; m++) begin
                do_reset();
                set_prio(0, p); mask_lim = 4'(m);
                raise(0);
                if (p < m) begin
                    wait_fetch(0, "R1 unmasked fetch");
                end else begin
                    no_fetch(6, "R1 masked stays");
                    chk(thread_mode, "R1 still thread", thread_mode, 1);
                    mask_lim = 4'd8;
                    #1;
                    wait_fetch(0, "R1 served after unmask");
                end
                pulse_first();
                do_done();
                chk(thread_mode && pushes == 8 && pops == 8, "R9 return", pops, 8);
            end
        end

        // R2 / R8 pair sweep
        for (int pa = 0; pa < 8; pa++) begin
            for (int pb = 0; pb < 8; pb++) begin
                do_reset();
                set_prio(1, pa); set_prio(2, pb);
                raise(1);
                wait_fetch(1, "R4 entry");
                pulse_first();
                raise(2);
                if (pb < pa) begin
                    wait_fetch(2, "R2 preempt");
                    pulse_first();
                    chk(act_depth == 2, "R10 depth", act_depth, 2);
                    chk(act_prio == pb, "R10 prio", act_prio, pb);
                    do_done();
                    chk(!tc_seen, "R9 no chain", tc_seen, 0);
                    chk(act_depth == 1, "R9 depth", act_depth, 1);
                    do_done();
                end else begin
                    no_fetch(6, "R2 no preempt");
                    do_done();
                    chk(tc_seen && tc_num == 2, "R8 tail chain", tc_num, 2);
                    chk(pops == 0 && pushes == 8, "R8 no beats", pops, 0);
                    pulse_first();
                    do_done();
                end
                chk(pushes == (pb < pa ? 16 : 8), "R4 push count", pushes, pb < pa ? 16 : 8);
                chk(pops == pushes, "R9 pop count", pops, pushes);
                chk(thread_mode, "R9 thread", thread_mode, 1);
            end
        end

        // R6 late arrival during stacking
        do_reset();
        set_prio(3, 5); set_prio(4, 2);
        raise(3);
        chk(vec_req && vec_num == 3, "R4 fetch A", vec_num, 3);
        raise(4);
        wait_fetch(4, "R6 retarget in stack");
        pulse_first();
        chk(pushes == 8, "R6 one frame", pushes, 8);
        chk(act_depth == 1 && act_prio == 2, "R6 depth/prio", act_prio, 2);
        do_done();
        chk(tc_seen && tc_num == 3, "R6 displaced re-pended", tc_num, 3);
        chk(pops == 0, "R6 chain no pop", pops, 0);
        pulse_first();
        do_done();
        chk(pops == 8 && thread_mode, "R9 final pop", pops, 8);

        // R6 late arrival after stacking, before first_exec
        do_reset();
        set_prio(3, 5); set_prio(4, 2);
        raise(3);
        wait_fetch(3, "R4 fetch A");
        while (stk_valid) @(negedge clk);
        raise(4);
        wait_fetch(4, "R6 retarget in wait");
        pulse_first();
        chk(pushes == 8 && act_depth == 1, "R6 no restack", pushes, 8);
        do_done();
        chk(tc_seen && tc_num == 3, "R6 chain back", tc_num, 3);
        pulse_first();
        do_done();

        // R7 after first_exec a higher request preempts normally
        do_reset();
        set_prio(3, 5); set_prio(4, 2);
        stall = 1;
        raise(3);
        wait_fetch(3, "R4 fetch A");
        pulse_first();
        raise(4);
        wait_fetch(4, "R7 preempt");
        pulse_first();
        chk(pushes == 16 && act_depth == 2, "R7 second frame", pushes, 16);
        do_done();
        do_done();
        chk(pops == 16 && thread_mode, "R9 unwind", pops, 16);
        stall = 0;

        // R3 ties and ordering
        do_reset();
        set_prio(5, 4); set_prio(6, 4);
        req_set[5] = 1; req_set[6] = 1;
        @(negedge clk); req_set = '0;
        wait_fetch(5, "R3 tie lowest number");
        pulse_first();
        do_done();
        chk(tc_seen && tc_num == 6, "R3 tie second", tc_num, 6);
        pulse_first();
        do_done();
        do_reset();
        set_prio(2, 3); set_prio(6, 1);
        req_set[2] = 1; req_set[6] = 1;
        @(negedge clk); req_set = '0;
        wait_fetch(6, "R3 lowest value");
        pulse_first();
        do_done();
        chk(tc_seen && tc_num == 2, "R3 next", tc_num, 2);
        pulse_first();
        do_done();

        // R10 full nesting
        do_reset();
        stall = 1;
        for (int i = 0; i < 8; i++) set_prio(i, 7 - i);
        for (int i = 0; i < 8; i++) begin
            raise(i);
            wait_fetch(i, "R10 nest fetch");
            pulse_first();
        end
        chk(act_depth == 8, "R10 depth 8", act_depth, 8);
        chk(act_prio == 0, "R10 top prio", act_prio, 0);
        chk(pushes == 64, "R4 pushes", pushes, 64);
        for (int i = 0; i < 8; i++) begin
            do_done();
            chk(!tc_seen, "R9 no chain", tc_seen, 0);
            chk(act_depth == 7 - i, "R9 unwind depth", act_depth, 7 - i);
        end
        chk(thread_mode && pops == 64, "R9 all popped", pops, 64);
        stall = 0;

        report();
    end
endmodule